// File: doc/BRIEF.md
# Signed Four-Digit Decimal Formatter

This block turns a two's-complement binary value into a fixed-width stream of six ASCII characters for a text sink. The result shows the four lowest decimal places of the value's magnitude, a sign, and a thousands separator. Leading zero places are blanked to spaces. The sign moves right so that it sits directly in front of the first digit shown. The separator becomes a comma only when the thousands digit is actually shown. Digits above the thousands place are silently dropped.

A conversion begins with a one-cycle start strobe while the block is idle. The value is reduced to a magnitude, turned into four BCD digits by a serial shift-and-adjust converter, and laid out into a six-character buffer. The buffer is then shifted out one character per accepted valid/ready handshake. Busy stays high from the accepted strobe until the sixth character has been taken.

Top module: `signed_dec_fmt`

## Requirements
- R1: While reset is asserted and after its release, busy_o and out_valid_o are low until a start strobe is accepted.
- R2: A start strobe while idle is accepted. busy_o is high from the following cycle until the sixth character is accepted, and it is low in the cycle after that acceptance.
- R3: Each conversion delivers exactly six 8-bit ASCII characters, one per cycle in which out_valid_o and out_ready_i are both high. While out_valid_o is high and out_ready_i is low, out_char_o holds its value.
- R4: The digit of each place (1000, 100, 10, 1, taken in that order) is (|value| / place) mod 10, so any digit above the thousands place is discarded.
- R5: A place whose digit is zero, with no digit shown before it, emits a space (0x20). The ones place always shows its digit.
- R6: Just before the first digit shown, one sign character is emitted: '-' (0x2D) for a negative input, a space (0x20) otherwise.
- R7: Directly after the thousands place output, ',' (0x2C) is emitted if a digit has been shown by then, else a space (0x20).
- R8: A shown digit d is emitted as 0x30 + d.
- R9: A start strobe while busy_o is high is ignored: the current stream completes with the original value and no further conversion follows.
- R10: The most negative input value is treated as magnitude 2^(VALUE_W-1)-1 (with the default 16-bit width, -32768 prints as "-2,767").

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe, sampled while idle |
| value_i | input | VALUE_W | Signed value to format, captured with the strobe |
| busy_o | output | 1 | High from the accepted strobe until the last character is accepted |
| out_valid_o | output | 1 | A character is presented on out_char_o |
| out_char_o | output | 8 | ASCII character, first character first |
| out_ready_i | input | 1 | Sink accepts the presented character |

## Verification
The hardest case to reach is a start strobe that arrives in the middle of a conversion, either during the serial BCD phase or while characters are stalled by the sink, combined with values at the edges of the magnitude range. The stimulus issues second strobes with a different value at both points, under three backpressure patterns (always ready, pseudo-random ready, mostly stalled). A scoreboard then confirms that only the original six characters appear. Most-negative, most-positive, exactly-ten-thousand and multiples of ten are driven directly, so that blank leading places, sign placement and the comma/space choice are each seen in both outcomes.

// File: rtl/fmt_pkg.sv
`timescale 1ns/1ps
package fmt_pkg;
  localparam int PLACES   = 4;
  localparam int CHARS    = PLACES + 2;
  localparam int BCD_W    = PLACES * 4;
  localparam int CHAR_W   = 8;

  localparam logic [CHAR_W-1:0] CH_SPACE = 8'h20;
  localparam logic [CHAR_W-1:0] CH_MINUS = 8'h2D;
  localparam logic [CHAR_W-1:0] CH_COMMA = 8'h2C;
  localparam logic [3:0]        CH_DIGIT_HI = 4'h3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_SEND = 2'd2
  } fmt_state_e;
endpackage

// File: rtl/fmt_magnitude.sv
`timescale 1ns/1ps
module fmt_magnitude #(
  parameter int VALUE_W = 16,
  localparam int MAG_W = VALUE_W - 1
) (
  input  logic [VALUE_W-1:0] value_i,
  output logic [MAG_W-1:0]   mag_o,
  output logic               neg_o
);
  logic [VALUE_W-1:0] negated;
  logic               is_min;

  always_comb begin
    neg_o   = value_i[VALUE_W-1];
    negated = ~value_i + {{(VALUE_W-1){1'b0}}, 1'b1};
    is_min  = neg_o && (value_i[MAG_W-1:0] == '0);
    if (is_min) begin
      mag_o = {MAG_W{1'b1}};
    end else if (neg_o) begin
      mag_o = negated[MAG_W-1:0];
    end else begin
      mag_o = value_i[MAG_W-1:0];
    end
  end
endmodule

// File: rtl/fmt_bcd_serial.sv
`timescale 1ns/1ps
module fmt_bcd_serial #(
  parameter int IN_W   = 15,
  parameter int DIGITS = 4,
  localparam int BCD_W = DIGITS * 4,
  localparam int CNT_W = $clog2(IN_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [IN_W-1:0]  bin_i,
  output logic             done_o,
  output logic [BCD_W-1:0] digits_o
);
  logic [IN_W-1:0]  sh_q,  sh_d;
  logic [BCD_W-1:0] bcd_q, bcd_d;
  logic [BCD_W-1:0] adj;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             step_en;

  for (genvar d = 0; d < DIGITS; d++) begin : g_adj
    assign adj[d*4 +: 4] = (bcd_q[d*4 +: 4] >= 4'd5) ? bcd_q[d*4 +: 4] + 4'd3
                                                     : bcd_q[d*4 +: 4];
  end

  assign step_en = load_i | run_q;

  always_comb begin
    sh_d  = sh_q;
    bcd_d = bcd_q;
    cnt_d = cnt_q;
    run_d = run_q;
    if (load_i) begin
      sh_d  = bin_i;
      bcd_d = '0;
      cnt_d = CNT_W'(IN_W);
      run_d = 1'b1;
    end else if (run_q) begin
      if (cnt_q != '0) begin
        bcd_d = {adj[BCD_W-2:0], sh_q[IN_W-1]};
        sh_d  = {sh_q[IN_W-2:0], 1'b0};
        cnt_d = cnt_q - 1'b1;
      end else begin
        run_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (step_en) begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (step_en) begin
      sh_q  <= sh_d;
      bcd_q <= bcd_d;
    end
  end

  assign done_o   = run_q && (cnt_q == '0);
  assign digits_o = bcd_q;

  for (genvar d = 0; d < DIGITS; d++) begin : g_chk
    // R4: every finished place holds a decimal digit
    assert_digit_range_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (bcd_q[d*4 +: 4] <= 4'd9));
  end

  // R3: one result per conversion
  assert_done_pulse_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/fmt_layout.sv
`timescale 1ns/1ps
module fmt_layout
  import fmt_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int NCHAR = DIGITS + 2
) (
  input  logic [DIGITS*4-1:0]     digits_i,
  input  logic                    neg_i,
  output logic [NCHAR*CHAR_W-1:0] chars_o
);
  always_comb begin
    logic       shown;
    logic [3:0] dig;
    int         slot;
    chars_o = {NCHAR{CH_SPACE}};
    shown   = 1'b0;
    slot    = 0;
    dig     = '0;
    for (int p = 0; p < DIGITS; p++) begin
      dig = digits_i[(DIGITS-1-p)*4 +: 4];
      if (shown || (dig != 4'd0) || (p == DIGITS-1)) begin
        if (!shown) begin
          chars_o[slot*CHAR_W +: CHAR_W] = neg_i ? CH_MINUS : CH_SPACE;
          slot  = slot + 1;
          shown = 1'b1;
        end
        chars_o[slot*CHAR_W +: CHAR_W] = {CH_DIGIT_HI, dig};
        slot = slot + 1;
      end else begin
        chars_o[slot*CHAR_W +: CHAR_W] = CH_SPACE;
        slot = slot + 1;
      end
      if (p == 0) begin
        chars_o[slot*CHAR_W +: CHAR_W] = shown ? CH_COMMA : CH_SPACE;
        slot = slot + 1;
      end
    end
  end
endmodule

// File: rtl/signed_dec_fmt.sv
`timescale 1ns/1ps
module signed_dec_fmt
  import fmt_pkg::*;
#(
  parameter int VALUE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [VALUE_W-1:0] value_i,
  output logic               busy_o,
  output logic               out_valid_o,
  output logic [7:0]         out_char_o,
  input  logic               out_ready_i
);
  localparam int MAG_W = VALUE_W - 1;
  localparam int PTR_W = $clog2(CHARS);
  localparam int BUF_W = CHARS * CHAR_W;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  fmt_state_e       state_q, state_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [BUF_W-1:0] buf_q;
  logic             neg_q;
  logic [MAG_W-1:0] mag;
  logic             neg_in;
  logic             start_acc;
  logic             conv_done;
  logic [BCD_W-1:0] digits;
  logic [BUF_W-1:0] chars;
  logic             take;
  logic             last_char;
  logic             ptr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fmt_magnitude #(.VALUE_W(VALUE_W)) u_mag (
    .value_i (value_i),
    .mag_o   (mag),
    .neg_o   (neg_in)
  );

  fmt_bcd_serial #(.IN_W(MAG_W), .DIGITS(PLACES)) u_bcd (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load_i   (start_acc),
    .bin_i    (mag),
    .done_o   (conv_done),
    .digits_o (digits)
  );

  fmt_layout #(.DIGITS(PLACES)) u_layout (
    .digits_i (digits),
    .neg_i    (neg_q),
    .chars_o  (chars)
  );

  assign start_acc = start_i && (state_q == ST_IDLE);
  assign take      = (state_q == ST_SEND) && out_ready_i;
  assign last_char = (ptr_q == PTR_W'(CHARS-1));
  assign ptr_en    = conv_done | take;

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    unique case (state_q)
      ST_IDLE: if (start_acc) state_d = ST_CONV;
      ST_CONV: if (conv_done) begin
        state_d = ST_SEND;
        ptr_d   = '0;
      end
      ST_SEND: if (out_ready_i) begin
        if (last_char) state_d = ST_IDLE;
        else           ptr_d   = ptr_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      if (ptr_en) ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (start_acc) neg_q <= neg_in;
    if (conv_done) buf_q <= chars;
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign out_valid_o = (state_q == ST_SEND);
  assign out_char_o  = buf_q[ptr_q*CHAR_W +: CHAR_W];

  logic [CHARS-1:0] minus_at;
  for (genvar c = 0; c < CHARS; c++) begin : g_minus
    assign minus_at[c] = (chars[c*CHAR_W +: CHAR_W] == CH_MINUS);
  end

  // R3: character held under backpressure
  assert_hold_char_R3 : assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_char_o)));

  // R2: busy drops right after the sixth character is taken
  assert_busy_drop_R2 : assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid_o && out_ready_i && last_char) |=> !busy_o);

  // R9: a strobe while busy does not replace the captured sign
  assert_ignore_start_R9 : assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_o && start_i) |=> $stable(neg_q));

  // R8: the last character of every layout is a digit
  assert_last_digit_R8 : assert property (@(posedge clk) disable iff (!rst_int_n)
    conv_done |-> (chars[(CHARS-1)*CHAR_W +: 4] <= 4'd9 &&
                   chars[(CHARS-1)*CHAR_W+4 +: 4] == CH_DIGIT_HI));

  // R6: exactly one minus sign for negative inputs, none otherwise
  assert_sign_once_R6 : assert property (@(posedge clk) disable iff (!rst_int_n)
    conv_done |-> ($countones(minus_at) == (neg_q ? 1 : 0)));
endmodule

// File: tb/signed_dec_fmt_tb.sv
`timescale 1ns/1ps
module signed_dec_fmt_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [W-1:0] value_i = '0;
  logic         busy_o;
  logic         out_valid_o;
  logic [7:0]   out_char_o;
  logic         out_ready_i = 1'b1;

  signed_dec_fmt #(.VALUE_W(W)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .value_i     (value_i),
    .busy_o      (busy_o),
    .out_valid_o (out_valid_o),
    .out_char_o  (out_char_o),
    .out_ready_i (out_ready_i)
  );

  always #2.5 clk = ~clk;

  int          n_checks = 0;
  int          n_fail   = 0;
  bit          finished = 0;
  byte         exp_q[$];
  string       tag_q[$];
  int          ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // expected stream from the requirements (R4..R8, R10)
  task automatic push_expect(int v, string tag);
    int  mag;
    bit  shown;
    byte s[6];
    int  k;
    mag = (v < 0) ? -v : v;
    if (v == -(1 << (W-1))) mag = (1 << (W-1)) - 1;
    shown = 0;
    k = 0;
    for (int i = 0; i < 4; i++) begin
      int pl;
      int d;
      pl = (i == 0) ? 1000 : (i == 1) ? 100 : (i == 2) ? 10 : 1;
      d  = (mag / pl) % 10;
      if (shown || d != 0 || i == 3) begin
        if (!shown) begin
          s[k] = (v < 0) ? 8'h2D : 8'h20;
          tag_q.push_back({tag, "/R6 sign"});
          k++;
          shown = 1;
        end
        s[k] = byte'(8'h30 + d);
        tag_q.push_back({tag, "/R8 digit"});
        k++;
      end else begin
        s[k] = 8'h20;
        tag_q.push_back({tag, "/R5 blank"});
        k++;
      end
      if (i == 0) begin
        s[k] = shown ? 8'h2C : 8'h20;
        tag_q.push_back({tag, "/R7 separator"});
        k++;
      end
    end
    for (int j = 0; j < 6; j++) exp_q.push_back(s[j]);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy_o) @(negedge clk);
  endtask

  // spoil: 0 none, 1 strobe during conversion, 2 strobe during streaming
  task automatic conv(int v, string tag, int spoil);
    push_expect(v, tag);
    wait_idle();
    @(posedge clk); #1;
    start_i = 1'b1;
    value_i = v[W-1:0];
    @(posedge clk); #1;
    start_i = 1'b0;
    @(negedge clk);
    check(busy_o == 1'b1, "R2", "busy after accepted strobe", busy_o, 1);
    if (spoil == 1) begin
      repeat (3) @(posedge clk);
      #1;
      start_i = 1'b1;
      value_i = ~v[W-1:0];
      @(posedge clk); #1;
      start_i = 1'b0;
    end else if (spoil == 2) begin
      while (!out_valid_o) @(negedge clk);
      @(posedge clk); #1;
      start_i = 1'b1;
      value_i = W'(-v - 1);
      @(posedge clk); #1;
      start_i = 1'b0;
    end
  endtask

  // ready pattern, driven away from the active edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (ready_mode)
      0:       out_ready_i = 1'b1;
      1:       out_ready_i = lfsr[0];
      default: out_ready_i = (lfsr[1:0] == 2'b00);
    endcase
  end

  // monitor / scoreboard
  bit       chk_low = 0;
  bit       prev_stall = 0;
  bit [7:0] prev_char = '0;
  int       pos = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (chk_low) begin
        check(busy_o == 1'b0, "R2", "busy after sixth character", busy_o, 0);
        chk_low = 0;
      end
      if (prev_stall) begin
        check(out_valid_o && out_char_o == prev_char, "R3", "held character",
              int'(out_char_o), int'(prev_char));
      end
      if (out_valid_o) begin
        check(busy_o == 1'b1, "R2", "busy while streaming", busy_o, 1);
        if (out_ready_i) begin
          if (exp_q.size() == 0) begin
            check(0, "R9", "unexpected character", int'(out_char_o), -1);
          end else begin
            byte   e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(out_char_o == e, t, "character", int'(out_char_o), int'(e));
          end
          pos++;
          if (pos == 6) begin
            pos = 0;
            chk_low = 1;
          end
        end
      end
      prev_stall = out_valid_o && !out_ready_i;
      prev_char  = out_char_o;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R3 watchdog: actual %0d expected %0d", 1, 0);
      report();
    end
  end

  initial begin
    #1;
    check(busy_o == 1'b0, "R1", "busy in reset", busy_o, 0);
    check(out_valid_o == 1'b0, "R1", "valid in reset", out_valid_o, 0);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);
    check(out_valid_o == 1'b0, "R1", "valid after reset", out_valid_o, 0);

    for (int m = 0; m < 3; m++) begin
      ready_mode = m;
      conv(0,      "R5", 0);
      conv(7,      "R8", 0);
      conv(-7,     "R6", 0);
      conv(50,     "R5", 0);
      conv(-305,   "R6", 0);
      conv(1005,   "R7", 0);
      conv(1234,   "R7", 0);
      conv(-1234,  "R6", 0);
      conv(9999,   "R8", 0);
      conv(10000,  "R4", 0);
      conv(12345,  "R4", 0);
      conv(-32768, "R10", 0);
      conv(32767,  "R10", 0);
      conv(-1,     "R6", 1);
      conv(1000,   "R9", 2);
      conv(-10,    "R9", 1);
      conv(-999,   "R9", 2);
      for (int r = 0; r < 8; r++) begin
        conv(int'($signed(lfsr ^ 16'h5A3C)), "R4", r % 3);
      end
    end

    wait_idle();
    repeat (40) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R3", "characters missing", exp_q.size(), 0);
    check(pos == 0, "R3", "partial stream", pos, 0);
    check(out_valid_o == 1'b0, "R9", "no stream after ignored strobes", out_valid_o, 0);
    report();
  end
endmodule